// File: doc/BRIEF.md
# Three-Phase Gate Guard with Latched Trip Shutdown

This block sits between a three-phase PWM generator and the gate drivers of the bridge. Each half-bridge leg receives a requested high-side and low-side command. The block turns those requests into gate signals. The outgoing switch is released at once. The incoming switch is held off for a programmable number of clock cycles before it turns on. A leg can never have both of its gates on at the same time. If both gates of a leg are requested together, the leg turns both gates off.

The block also watches five trip inputs. Three are overcurrent comparator outputs, one per phase. The other two are flags for an absolute phase-current limit and an absolute phase-voltage limit. These inputs are asynchronous. Each one passes through a two-stage synchronizer and a glitch filter. A trip that stays high long enough forces every gate off within a few tens of nanoseconds. The fault is then latched. A one-hot cause register records which input tripped first. A clear request is accepted only once every synchronized trip has gone low. After an accepted clear, the legs start from all-off and wait out a complete dead time before any gate turns on.

Top module: `gg_gate_guard`

## Requirements
- R1: When a leg's high and low commands are both 1, both of its gates are driven to 0. No leg ever shows gateHi and gateLo both at 1.
- R2: Leg i is controlled by cmdHi[i] and cmdLo[i]. When a leg's command changes, the outgoing gate drops on the clock edge that samples the change. The incoming gate rises exactly deadCycles+1 edges after that edge. Both gates stay at 0 in between.
- R3: With deadCycles = 0, a newly requested gate still has its gates at 0 for one full cycle. It turns on on the second edge after the change is sampled.
- R4: A change in a leg's command during that leg's dead-time interval restarts the interval. The new gate rises deadCycles+1 edges after the later change.
- R5: While faultActive is 1, every gate output is 0, whatever the commands are.
- R6: A trip input is ignored if it is high for fewer than FILT_CYCLES consecutive synchronized cycles. In that case faultActive stays 0 and the gates are unaffected.
- R7: Consider a trip input set between clock edges and held high. On the (FILT_CYCLES+2)th edge after it is set, faultActive becomes 1 and all gates become 0. One edge earlier, the outputs are unchanged. With the default of 4 at 200 MHz this is 30 ns, well inside a 1 µs shutdown budget.
- R8: While any synchronized trip input is high, faultClear has no effect. The fault and its cause stay latched.
- R9: An accepted faultClear zeroes faultActive and faultCause on the next edge. The gates stay at 0 for deadCycles+1 further edges and then follow the current commands.
- R10: faultCause is one-hot and sticky until an accepted clear. Bit 0, bit 1 and bit 2 are the overcurrent trips for phases 0, 1 and 2. Bit 3 is the current limit and bit 4 is the voltage limit. Only the first trip to qualify is recorded. If several qualify on the same edge, the lowest bit wins.
- R11: While rstN is 0, all gates, faultActive and faultCause are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| deadCycles | input | DT_W | Dead-time length in clock cycles |
| cmdHi | input | NUM_LEGS | Requested high-side state per leg |
| cmdLo | input | NUM_LEGS | Requested low-side state per leg |
| ocTrip | input | NUM_LEGS | Asynchronous overcurrent comparator trips, one per phase |
| curLimit | input | 1 | Asynchronous absolute phase-current limit flag |
| voltLimit | input | 1 | Asynchronous absolute phase-voltage limit flag |
| faultClear | input | 1 | Request to clear a latched fault |
| gateHi | output | NUM_LEGS | High-side gate drive per leg |
| gateLo | output | NUM_LEGS | Low-side gate drive per leg |
| faultActive | output | 1 | Latched fault, all gates forced off |
| faultCause | output | NUM_LEGS+2 | One-hot record of the first trip |

## Verification
The properties assume three things about the inputs:
- faultClear and the commands are synchronous to clk.
- deadCycles does not change while a leg is counting a dead time that the test depends on.
- Trip inputs, although asynchronous, stay at each level for at least one clock period, so the synchronizer sees every intended pulse.

The stimulus meets these assumptions in the following way. Every input changes only on the falling clock edge, so it is stable well before the next rising edge. deadCycles changes only at a point where the new value is loaded along with the change it is meant for. Trip pulses last whole cycles, including the deliberately short glitch.

// File: rtl/gg_pkg.sv
package gg_pkg;

  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_HI  = 2'd1,
    LEG_LO  = 2'd2
  } legState_e;

  // Strobes from the fault control to every leg datapath.
  typedef struct packed {
    logic forceOff;
  } guardStrobe_t;

endpackage

// File: rtl/gg_fault_ctrl.sv
module gg_fault_ctrl
  import gg_pkg::*;
#(
  parameter int NUM_TRIPS   = 5,
  parameter int FILT_CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_TRIPS-1:0] tripIn,
  input  logic                 faultClear,
  output guardStrobe_t         strobe,
  output logic                 faultActive,
  output logic [NUM_TRIPS-1:0] faultCause
);

  localparam int CNT_W = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYCLES - 1);

  logic [NUM_TRIPS-1:0] syncA, syncB, qual;
  logic [CNT_W-1:0]     runLen [NUM_TRIPS];
  logic                 faultQ;
  logic [NUM_TRIPS-1:0] causeQ;
  logic [NUM_TRIPS-1:0] firstBit;
  logic                 anyQual, anySync;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= tripIn;
      syncB <= syncA;
    end
  end

  // Per-trip run-length glitch filter, saturating at the qualify count.
  for (genvar t = 0; t < NUM_TRIPS; t++) begin : g_filt
    always_ff @(posedge clk) begin
      if (!rstN || !syncB[t])      runLen[t] <= '0;
      else if (runLen[t] != CNT_LAST) runLen[t] <= runLen[t] + 1'b1;
    end
    assign qual[t] = syncB[t] && (runLen[t] == CNT_LAST);
  end

  assign anyQual  = |qual;
  assign anySync  = |syncB;
  assign firstBit = qual & (~qual + 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultQ <= 1'b0;
      causeQ <= '0;
    end else if (anyQual) begin
      faultQ <= 1'b1;
      if (!faultQ) causeQ <= firstBit;
    end else if (faultQ && faultClear && !anySync) begin
      faultQ <= 1'b0;
      causeQ <= '0;
    end
  end

  assign strobe.forceOff = faultQ | anyQual;
  assign faultActive     = faultQ;
  assign faultCause      = causeQ;

endmodule

// File: rtl/gg_leg.sv
module gg_leg
  import gg_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdHi,
  input  logic            cmdLo,
  input  logic [DT_W-1:0] deadCycles,
  input  guardStrobe_t    strobe,
  output logic            gateHi,
  output logic            gateLo
);

  legState_e       req, pend, active;
  logic [DT_W-1:0] dtCnt;

  always_comb begin
    unique case ({cmdHi, cmdLo})
      2'b10:   req = LEG_HI;
      2'b01:   req = LEG_LO;
      default: req = LEG_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend   <= LEG_OFF;
      active <= LEG_OFF;
      dtCnt  <= '0;
    end else if (strobe.forceOff || req != pend) begin
      // Fault or new request: release both gates and restart dead time.
      pend   <= req;
      active <= LEG_OFF;
      dtCnt  <= deadCycles;
    end else if (active != pend) begin
      if (dtCnt != '0) dtCnt  <= dtCnt - 1'b1;
      else             active <= pend;
    end
  end

  assign gateHi = (active == LEG_HI);
  assign gateLo = (active == LEG_LO);

endmodule

// File: rtl/gg_gate_guard.sv
module gg_gate_guard
  import gg_pkg::*;
#(
  parameter int NUM_LEGS    = 3,
  parameter int DT_W        = 8,
  parameter int FILT_CYCLES = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [DT_W-1:0]       deadCycles,
  input  logic [NUM_LEGS-1:0]   cmdHi,
  input  logic [NUM_LEGS-1:0]   cmdLo,
  input  logic [NUM_LEGS-1:0]   ocTrip,
  input  logic                  curLimit,
  input  logic                  voltLimit,
  input  logic                  faultClear,
  output logic [NUM_LEGS-1:0]   gateHi,
  output logic [NUM_LEGS-1:0]   gateLo,
  output logic                  faultActive,
  output logic [NUM_LEGS+1:0]   faultCause
);

  localparam int NUM_TRIPS = NUM_LEGS + 2;

  guardStrobe_t         strobe;
  logic [NUM_TRIPS-1:0] tripVec;

  assign tripVec = {voltLimit, curLimit, ocTrip};

  gg_fault_ctrl #(.NUM_TRIPS(NUM_TRIPS), .FILT_CYCLES(FILT_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .tripIn(tripVec), .faultClear(faultClear),
    .strobe(strobe), .faultActive(faultActive), .faultCause(faultCause)
  );

  for (genvar l = 0; l < NUM_LEGS; l++) begin : g_leg
    gg_leg #(.DT_W(DT_W)) u_leg (
      .clk(clk), .rstN(rstN), .cmdHi(cmdHi[l]), .cmdLo(cmdLo[l]),
      .deadCycles(deadCycles), .strobe(strobe),
      .gateHi(gateHi[l]), .gateLo(gateLo[l])
    );
  end

endmodule

// File: rtl/gg_guard_checker.sv
module gg_guard_checker #(
  parameter int NUM_LEGS = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                faultClear,
  input logic [NUM_LEGS-1:0] gateHi,
  input logic [NUM_LEGS-1:0] gateLo,
  input logic                faultActive,
  input logic [NUM_LEGS+1:0] faultCause
);

  for (genvar l = 0; l < NUM_LEGS; l++) begin : g_chk
    a_r1_never_both_on: assert property (@(posedge clk) disable iff (!rstN)
      !(gateHi[l] && gateLo[l]));
    a_r2_hi_after_gap: assert property (@(posedge clk) disable iff (!rstN)
      $rose(gateHi[l]) |-> !$past(gateLo[l]));
    a_r2_lo_after_gap: assert property (@(posedge clk) disable iff (!rstN)
      $rose(gateLo[l]) |-> !$past(gateHi[l]));
  end

  a_r5_fault_gates_off: assert property (@(posedge clk) disable iff (!rstN)
    faultActive |-> (gateHi == '0 && gateLo == '0));

  a_r8_fault_holds: assert property (@(posedge clk) disable iff (!rstN)
    (faultActive && !faultClear) |=> faultActive);

  a_r9_release_needs_clear: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultActive) |-> $past(faultClear));

  a_r10_cause_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(faultCause) && (faultActive == (faultCause != '0)));

  a_r10_cause_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (faultActive && $past(faultActive)) |-> $stable(faultCause));

endmodule

bind gg_gate_guard gg_guard_checker #(.NUM_LEGS(NUM_LEGS)) u_guard_chk (
  .clk(clk), .rstN(rstN), .faultClear(faultClear), .gateHi(gateHi),
  .gateLo(gateLo), .faultActive(faultActive), .faultCause(faultCause)
);

// File: tb/gg_gate_guard_test.sv
`timescale 1ns/100ps
module gg_gate_guard_test;

  localparam int DT_W = 8;
  localparam int F    = 4;
  localparam int D    = 3;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [DT_W-1:0] deadCycles = DT_W'(D);
  logic [2:0]      cmdHi = '0, cmdLo = '0, ocTrip = '0;
  logic            curLimit = 1'b0, voltLimit = 1'b0, faultClear = 1'b0;
  logic [2:0]      gateHi, gateLo;
  logic            faultActive;
  logic [4:0]      faultCause;

  gg_gate_guard #(.NUM_LEGS(3), .DT_W(DT_W), .FILT_CYCLES(F)) uut (
    .clk(clk), .rstN(rstN), .deadCycles(deadCycles), .cmdHi(cmdHi),
    .cmdLo(cmdLo), .ocTrip(ocTrip), .curLimit(curLimit),
    .voltLimit(voltLimit), .faultClear(faultClear), .gateHi(gateHi),
    .gateLo(gateLo), .faultActive(faultActive), .faultCause(faultCause)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         at;
    logic [2:0] hi;
    logic [2:0] lo;
    logic       flt;
    logic [4:0] cause;
    string      tag;
  } expItem_t;

  expItem_t sb[$];
  int checks = 0, failures = 0;
  bit done = 0;

  task automatic push(int at, logic [2:0] hi, logic [2:0] lo, logic flt,
                      logic [4:0] cause, string tag);
    expItem_t e;
    e.at = at; e.hi = hi; e.lo = lo; e.flt = flt; e.cause = cause; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic waitc(int k);
    repeat (k) @(negedge clk);
  endtask

  // Monitor: compare every expectation due in this cycle.
  always @(negedge clk) begin
    for (int k = sb.size() - 1; k >= 0; k--) begin
      if (sb[k].at == cyc) begin
        checks++;
        if (gateHi !== sb[k].hi || gateLo !== sb[k].lo ||
            faultActive !== sb[k].flt || faultCause !== sb[k].cause) begin
          failures++;
          $display("FAIL %s cyc=%0d got hi=%b lo=%b flt=%b cause=%b expected hi=%b lo=%b flt=%b cause=%b",
                   sb[k].tag, cyc, gateHi, gateLo, faultActive, faultCause,
                   sb[k].hi, sb[k].lo, sb[k].flt, sb[k].cause);
        end
        sb.delete(k);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired got running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n, m;
    waitc(3);
    n = cyc; push(n + 1, 3'b000, 3'b000, 0, 5'b0, "R11 reset state");
    waitc(1); rstN = 1'b1;
    waitc(2);

    // R2: dead time from all-off
    @(negedge clk); n = cyc;
    cmdHi = 3'b001; cmdLo = 3'b110;
    push(n + D + 1, 3'b000, 3'b000, 0, 5'b0, "R2 gap");
    push(n + D + 2, 3'b001, 3'b110, 0, 5'b0, "R2 turn on");
    waitc(D + 4);

    // R4: change during dead time restarts
    @(negedge clk); n = cyc;
    cmdHi = 3'b000; cmdLo = 3'b111;
    push(n + 1, 3'b000, 3'b110, 0, 5'b0, "R2 immediate release");
    waitc(2);
    cmdHi = 3'b001; cmdLo = 3'b110;
    push(n + D + 2, 3'b000, 3'b110, 0, 5'b0, "R4 restart hold");
    push(n + D + 3, 3'b000, 3'b110, 0, 5'b0, "R4 restart hold");
    push(n + D + 4, 3'b001, 3'b110, 0, 5'b0, "R4 restart on");
    waitc(D + 6);

    // R1: both requested
    @(negedge clk); n = cyc;
    cmdHi = 3'b111; cmdLo = 3'b111;
    push(n + 1, 3'b000, 3'b000, 0, 5'b0, "R1 both requested");
    push(n + D + 5, 3'b000, 3'b000, 0, 5'b0, "R1 stays off");
    waitc(D + 6);

    // R3: zero dead time
    @(negedge clk); n = cyc;
    deadCycles = '0; cmdHi = 3'b101; cmdLo = 3'b010;
    push(n + 1, 3'b000, 3'b000, 0, 5'b0, "R3 one off cycle");
    push(n + 2, 3'b101, 3'b010, 0, 5'b0, "R3 on");
    waitc(3);
    deadCycles = DT_W'(D);

    // R6: short glitch ignored
    @(negedge clk); n = cyc;
    ocTrip = 3'b010;
    waitc(F - 1);
    ocTrip = 3'b000;
    push(n + 12, 3'b101, 3'b010, 0, 5'b0, "R6 glitch ignored");
    waitc(12);

    // R7: voltage limit trip latency
    @(negedge clk); n = cyc;
    voltLimit = 1'b1;
    push(n + F + 1, 3'b101, 3'b010, 0, 5'b0, "R7 before shutdown");
    push(n + F + 2, 3'b000, 3'b000, 1, 5'b10000, "R7 shutdown");
    waitc(F + 3);

    // R5 / R10: later trip and command change while faulted
    @(negedge clk); n = cyc;
    ocTrip = 3'b001; cmdHi = 3'b010; cmdLo = 3'b101;
    push(n + F + 4, 3'b000, 3'b000, 1, 5'b10000, "R5 R10 sticky, gates held off");
    waitc(F + 5);

    // R8: clear ignored while trips high
    @(negedge clk); faultClear = 1'b1;
    @(negedge clk); faultClear = 1'b0; n = cyc;
    push(n + 2, 3'b000, 3'b000, 1, 5'b10000, "R8 clear refused");
    waitc(3);

    // R9: accepted clear and resume through dead time
    @(negedge clk); ocTrip = 3'b000; voltLimit = 1'b0;
    waitc(4);
    faultClear = 1'b1; m = cyc;
    push(m + 1, 3'b000, 3'b000, 0, 5'b0, "R9 cleared");
    push(m + D + 1, 3'b000, 3'b000, 0, 5'b0, "R9 dead time after clear");
    push(m + D + 2, 3'b010, 3'b101, 0, 5'b0, "R9 resume");
    @(negedge clk); faultClear = 1'b0;
    waitc(D + 3);

    // R10: simultaneous trips, lowest bit wins
    @(negedge clk); n = cyc;
    ocTrip = 3'b100; curLimit = 1'b1;
    push(n + F + 2, 3'b000, 3'b000, 1, 5'b00100, "R10 priority");
    waitc(F + 3);
    ocTrip = 3'b000; curLimit = 1'b0;
    waitc(3);
    faultClear = 1'b1; m = cyc;
    push(m + 1, 3'b000, 3'b000, 0, 5'b0, "R9 second clear");
    push(m + D + 2, 3'b010, 3'b101, 0, 5'b0, "R9 second resume");
    @(negedge clk); faultClear = 1'b0;
    waitc(D + 4);

    if (sb.size() != 0) begin
      failures++;
      $display("FAIL scoreboard got %0d pending expected 0", sb.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule